// File: doc/BRIEF.md
# Exception Preemption Arbiter

This block decides, every cycle, whether a pending exception is allowed to interrupt the processor, and which one. Exceptions are numbered. Three of them have fixed priorities: reset, the non-maskable interrupt (NMI) and hard fault. The system exceptions and `NUM_IRQ` external interrupts each take an 8-bit priority from the configuration inputs. A lower value is more urgent. A split input divides each priority into two parts. The upper bits form a preemption group and the lower bits form a subpriority. Only the group decides whether one exception can interrupt another.

The block holds the pending bits and a stack of nested handlers. The top of the stack sets the running mask level. A global priority floor (basepri), a disable-all-but-critical mask (primask) and a stronger fault mask (faultmask) narrow the eligible set further. When a winner exists, `take_o` is raised with its number. At the clock edge that ends that cycle, the winner's pending bit clears and the winner is pushed as the new running handler. A return strobe pops the stack and clears faultmask. Vector fetch and register stacking are done elsewhere.

Top module: `exc_preempt_arb`

## Requirements
- R1: Bit n of `pend_set_i` pends exception n. The valid numbers are:
  - reset 1, NMI 2, hard fault 3;
  - 4, 5, 6, 11, 12, 14, 15;
  - interrupt k at 16+k.

  Set requests on numbers 0, 7 to 10 and 13 are ignored. Their `pend_o` bit stays 0 and they are never taken.
- R2: `take_o` is high when at least one pending exception is eligible. `take_num_o` then names the eligible exception with the smallest full priority value. A tie goes to the lowest exception number.
- R3: Only the upper `PRIO_BITS` bits of each priority and of `basepri_i` are significant. The lower bits are treated as zero.
- R4: With `sub_bits_i` = s, the lowest s priority bits are subpriority and the rest form the group. An exception preempts only when its group value is strictly below that of the running handler. An exception in the same group never preempts, even if its subpriority is better.
- R5: After a take, `active_num_o` shows the taken number from the next cycle on, and the running level becomes its group. `ret_i` restores the previous handler, or 0 in thread mode. `take_o` stays low in a cycle with `ret_i` and when the nesting stack (`NUM_EXC` entries) is full.
- R6: A `basepri_i` value that is nonzero after truncation blocks programmable exceptions whose group is greater than or equal to basepri's group. A value of zero disables this mask.
- R7: `primask_i` = 1 blocks every exception except reset, NMI and hard fault.
- R8: `fm_wr_i` loads `fm_din_i` into faultmask (`faultmask_o`). Any `ret_i` clears faultmask and takes precedence over a write in the same cycle. While set, faultmask blocks everything except reset and NMI.
- R9: After reset:
  - `pend_o` is 0, `take_o` is 0, `active_num_o` is 0 and `faultmask_o` is 0.
  - The taken exception's pending bit is cleared at the edge that ends the take cycle, even if it was set again in that cycle.
- R10: The fixed priorities rank reset above NMI, and NMI above hard fault. All three rank above every programmable priority, and basepri never blocks them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_set_i | input | NUM_EXC | Per-number pend request |
| prio_i | input | NUM_EXC x 8 | Priority per exception number (fixed ones ignored) |
| sub_bits_i | input | 3 | Number of low-order subpriority bits |
| primask_i | input | 1 | Block all but reset, NMI, hard fault |
| basepri_i | input | 8 | Priority floor, 0 = off |
| fm_wr_i | input | 1 | Faultmask load strobe |
| fm_din_i | input | 1 | Faultmask load value |
| ret_i | input | 1 | Exception return strobe |
| take_o | output | 1 | A pending exception preempts in this cycle |
| take_num_o | output | NUM_W | Number of the preempting exception |
| active_num_o | output | NUM_W | Running handler number, 0 in thread mode |
| pend_o | output | NUM_EXC | Pending bits |
| faultmask_o | output | 1 | Faultmask state |

## Verification
The assertions check on every cycle:
- the masks cannot let a forbidden exception through: nothing above hard fault under primask, nothing above NMI under faultmask;
- a take always names a valid number, clears its pending bit and becomes the running handler;
- a return always clears faultmask;
- the nesting stack neither overflows nor sees a push and a pop together.

Only the bench scenarios can show the rest. These are the choice of winner under ties and truncated priority bits, the refusal of same-group preemption for every split setting, the restoration of the earlier level on return, and the basepri threshold. The bench compares every cycle of directed and swept stimulus against an arithmetic model of those rules.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
   localparam int unsigned PRIO_W   = 8;
   localparam int unsigned KEY_W    = PRIO_W + 1;
   localparam int unsigned EXC_NMI  = 2;
   localparam int unsigned EXC_HARD = 3;
   localparam int unsigned EXC_IRQ0 = 16;

   // key: bit 8 clear for the three fixed exceptions, set for programmable ones
   typedef logic [KEY_W-1:0] key_t;

   function automatic logic exc_num_valid(int unsigned n);
      return (n >= 1 && n <= 6) || n == 11 || n == 12 || n == 14 || n == 15 || n >= EXC_IRQ0;
   endfunction

   function automatic key_t fixed_key(int unsigned n);
      return key_t'(n - 1);
   endfunction
endpackage

// File: rtl/exc_key_gen.sv
module exc_key_gen
   import exc_arb_pkg::*;
#(
   parameter int unsigned NUM_EXC   = 20,
   parameter int unsigned PRIO_BITS = 3
) (
   input  logic [NUM_EXC-1:0][PRIO_W-1:0] prio_i,
   input  logic [2:0]                     sub_bits_i,
   output key_t [NUM_EXC-1:0]             full_key_o,
   output key_t [NUM_EXC-1:0]             grp_key_o
);
   localparam logic [PRIO_W-1:0] IMPL_MASK = PRIO_W'(8'hFF << (PRIO_W - PRIO_BITS));

   logic [PRIO_W-1:0] grp_mask;
   assign grp_mask = PRIO_W'(8'hFF << sub_bits_i);

   for (genvar e = 0; e < NUM_EXC; e++) begin : g_exc
      if (e >= 1 && e <= EXC_HARD) begin : g_fixed
         logic unused_prio_bits;
         assign unused_prio_bits = ^prio_i[e];
         assign full_key_o[e]    = fixed_key(e);
         assign grp_key_o[e]     = fixed_key(e);
      end else begin : g_prog
         logic [PRIO_W-1:0] imp;
         assign imp           = prio_i[e] & IMPL_MASK;
         assign full_key_o[e] = {1'b1, imp};
         assign grp_key_o[e]  = {1'b1, imp & grp_mask};
      end
   end
endmodule

// File: rtl/exc_winner_sel.sv
module exc_winner_sel
   import exc_arb_pkg::*;
#(
   parameter int unsigned NUM_EXC = 20,
   parameter int unsigned NUM_W   = 5
) (
   input  logic [NUM_EXC-1:0] elig_i,
   input  key_t [NUM_EXC-1:0] key_i,
   output logic               found_o,
   output logic [NUM_W-1:0]   num_o
);
   key_t best;

   // ascending scan with strict compare keeps the lowest number on ties
   always_comb begin
      found_o = 1'b0;
      num_o   = '0;
      best    = '1;
      for (int i = 0; i < NUM_EXC; i++) begin
         if (elig_i[i] && (!found_o || key_i[i] < best)) begin
            found_o = 1'b1;
            best    = key_i[i];
            num_o   = NUM_W'(i);
         end
      end
   end
endmodule

// File: rtl/exc_nest_stack.sv
module exc_nest_stack #(
   parameter int unsigned DEPTH = 20,
   parameter int unsigned W     = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] top_o,
   output logic         empty_o,
   output logic         full_o
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]     mem [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] wr_idx, top_idx;

   assign empty_o = (cnt == '0);
   assign full_o  = (cnt == CNT_W'(DEPTH));
   assign wr_idx  = IDX_W'(cnt);
   assign top_idx = IDX_W'(cnt - 1'b1);
   assign top_o   = empty_o ? '0 : mem[top_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (push_i && !full_o)    cnt <= cnt + 1'b1;
      else if (pop_i && !empty_o)    cnt <= cnt - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push_i && !full_o) mem[wr_idx] <= din_i;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o); // R5
   AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i)); // R5
endmodule

// File: rtl/exc_preempt_arb.sv
module exc_preempt_arb
   import exc_arb_pkg::*;
#(
   parameter  int unsigned NUM_IRQ   = 4,
   parameter  int unsigned PRIO_BITS = 3,
   localparam int unsigned NUM_EXC   = EXC_IRQ0 + NUM_IRQ,
   localparam int unsigned NUM_W     = $clog2(NUM_EXC)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_EXC-1:0]            pend_set_i,
   input  logic [NUM_EXC-1:0][PRIO_W-1:0] prio_i,
   input  logic [2:0]                    sub_bits_i,
   input  logic                          primask_i,
   input  logic [PRIO_W-1:0]             basepri_i,
   input  logic                          fm_wr_i,
   input  logic                          fm_din_i,
   input  logic                          ret_i,
   output logic                          take_o,
   output logic [NUM_W-1:0]              take_num_o,
   output logic [NUM_W-1:0]              active_num_o,
   output logic [NUM_EXC-1:0]            pend_o,
   output logic                          faultmask_o
);
   localparam logic [PRIO_W-1:0] IMPL_MASK = PRIO_W'(8'hFF << (PRIO_W - PRIO_BITS));

   if (NUM_IRQ < 1 || NUM_IRQ > 240) begin : g_bad_irq
      $error("NUM_IRQ must lie in 1..240");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > PRIO_W) begin : g_bad_prio
      $error("PRIO_BITS must lie in 1..8");
   end

   logic [NUM_EXC-1:0] valid_vec, pend_q, elig, clr_vec;
   logic               fm_q, found, thread, stk_full;
   logic [NUM_W-1:0]   win_num, top_num;
   key_t [NUM_EXC-1:0] full_key, grp_key;
   logic [PRIO_W-1:0]  grp_mask, bp_imp;
   logic               bp_on;
   key_t               bp_key;
   logic [KEY_W:0]     run_lvl;

   for (genvar v = 0; v < NUM_EXC; v++) begin : g_valid
      assign valid_vec[v] = exc_num_valid(v);
   end

   exc_key_gen #(.NUM_EXC(NUM_EXC), .PRIO_BITS(PRIO_BITS)) u_keys (
      .prio_i(prio_i), .sub_bits_i(sub_bits_i),
      .full_key_o(full_key), .grp_key_o(grp_key));

   assign grp_mask = PRIO_W'(8'hFF << sub_bits_i);
   assign bp_imp   = basepri_i & IMPL_MASK;
   assign bp_on    = (bp_imp != '0);
   assign bp_key   = {1'b1, bp_imp & grp_mask};
   assign run_lvl  = thread ? '1 : {1'b0, grp_key[top_num]};

   for (genvar e = 0; e < NUM_EXC; e++) begin : g_elig
      logic below_run;
      assign below_run = ({1'b0, grp_key[e]} < run_lvl);
      if (e <= EXC_NMI) begin : g_crit
         assign elig[e] = pend_q[e] && below_run;
      end else if (e == EXC_HARD) begin : g_hard
         assign elig[e] = pend_q[e] && below_run && !fm_q;
      end else begin : g_prog
         assign elig[e] = pend_q[e] && below_run && !fm_q && !primask_i
                          && !(bp_on && grp_key[e] >= bp_key);
      end
   end

   exc_winner_sel #(.NUM_EXC(NUM_EXC), .NUM_W(NUM_W)) u_win (
      .elig_i(elig), .key_i(full_key), .found_o(found), .num_o(win_num));

   assign take_o     = found && !ret_i && !stk_full;
   assign take_num_o = win_num;
   assign clr_vec    = take_o ? (NUM_EXC'(1) << win_num) : '0;

   exc_nest_stack #(.DEPTH(NUM_EXC), .W(NUM_W)) u_stack (
      .clk(clk), .rst_n(rst_n), .push_i(take_o), .pop_i(ret_i), .din_i(win_num),
      .top_o(top_num), .empty_o(thread), .full_o(stk_full));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         fm_q   <= 1'b0;
      end else begin
         pend_q <= (pend_q | (pend_set_i & valid_vec)) & ~clr_vec;
         if (ret_i)        fm_q <= 1'b0;
         else if (fm_wr_i) fm_q <= fm_din_i;
      end
   end

   assign active_num_o = top_num;
   assign pend_o       = pend_q;
   assign faultmask_o  = fm_q;

   AST_TAKE_VALID_NUM: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> valid_vec[take_num_o]); // R1
   AST_TAKE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> !pend_o[$past(take_num_o)]); // R9
   AST_TAKE_BECOMES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> active_num_o == $past(take_num_o)); // R5
   AST_PRIMASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && primask_i) |-> take_num_o <= NUM_W'(EXC_HARD)); // R7
   AST_FAULTMASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && faultmask_o) |-> take_num_o <= NUM_W'(EXC_NMI)); // R8
   AST_RETURN_CLEARS_FM: assert property (@(posedge clk) disable iff (!rst_n)
      ret_i |=> !faultmask_o); // R8
endmodule

// File: tb/exc_preempt_arb_tb.sv
module exc_preempt_arb_tb;
   localparam int NI  = 4;
   localparam int PB  = 3;
   localparam int NE  = 16 + NI;
   localparam int NW  = $clog2(NE);
   localparam int IMPL = (255 << (8 - PB)) & 255;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [NE-1:0]       pend_set;
   logic [NE-1:0][7:0]  prio;
   logic [2:0]          sub;
   logic                pm, fm_wr, fm_din, ret;
   logic [7:0]          bp;
   logic                take, fmo;
   logic [NW-1:0]       take_num, act;
   logic [NE-1:0]       pendo;

   exc_preempt_arb #(.NUM_IRQ(NI), .PRIO_BITS(PB)) u_dut (
      .clk(clk), .rst_n(rst_n), .pend_set_i(pend_set), .prio_i(prio), .sub_bits_i(sub),
      .primask_i(pm), .basepri_i(bp), .fm_wr_i(fm_wr), .fm_din_i(fm_din), .ret_i(ret),
      .take_o(take), .take_num_o(take_num), .active_num_o(act), .pend_o(pendo),
      .faultmask_o(fmo));

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   bit m_pend [NE];
   int m_stk  [NE];
   int m_sp;
   bit m_fm;

   function automatic bit vld(int n);
      return (n >= 1 && n <= 6) || n == 11 || n == 12 || n == 14 || n == 15 || (n >= 16 && n < NE);
   endfunction

   function automatic int gmask();
      return (255 << sub) & 255;
   endfunction

   function automatic int fkey(int n);
      if (n >= 1 && n <= 3) return n - 1;
      return 256 + (prio[n] & IMPL);
   endfunction

   function automatic int gkey(int n);
      if (n >= 1 && n <= 3) return n - 1;
      return 256 + (prio[n] & IMPL & gmask());
   endfunction

   function automatic bit ref_elig(int n);
      int lvl;
      int bpi;
      lvl = (m_sp == 0) ? 1024 : gkey(m_stk[m_sp-1]);
      if (!(gkey(n) < lvl)) return 0;
      if (n <= 2) return 1;
      if (m_fm) return 0;
      if (n == 3) return 1;
      if (pm) return 0;
      bpi = bp & IMPL;
      if (bpi != 0 && gkey(n) >= 256 + (bpi & gmask())) return 0;
      return 1;
   endfunction

   function automatic int ref_win();
      int best = 0;
      int bk = 0;
      for (int n = 1; n < NE; n++)
         if (m_pend[n] && ref_elig(n) && (best == 0 || fkey(n) < bk)) begin
            best = n;
            bk = fkey(n);
         end
      return best;
   endfunction

   function automatic logic [NE-1:0] pend_vec();
      logic [NE-1:0] v;
      for (int n = 0; n < NE; n++) v[n] = m_pend[n];
      return v;
   endfunction

   task automatic clear_inputs();
      pend_set = '0;
      for (int i = 0; i < NE; i++) prio[i] = 8'hFF;
      sub = 3'd0; pm = 1'b0; bp = 8'h00; fm_wr = 1'b0; fm_din = 1'b0; ret = 1'b0;
   endtask

   task automatic do_reset();
      clear_inputs();
      rst_n = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      for (int n = 0; n < NE; n++) m_pend[n] = 0;
      m_sp = 0; m_fm = 0;
      rst_n = 1'b1;
   endtask

   task automatic step(input string tag);
      int w, ea;
      bit et;
      @(negedge clk);
      w  = ref_win();
      et = (w != 0) && !ret && (m_sp < NE);
      ea = (m_sp == 0) ? 0 : m_stk[m_sp-1];
      n_vec++;
      if (take !== et || (et && take_num !== NW'(w)) || act !== NW'(ea) ||
          fmo !== m_fm || pendo !== pend_vec()) begin
         n_bad++;
         $display("FAIL %s: got take=%0b num=%0d act=%0d fm=%0b pend=%h, expected take=%0b num=%0d act=%0d fm=%0b pend=%h",
                  tag, take, take_num, act, fmo, pendo, et, w, ea, m_fm, pend_vec());
      end
      @(posedge clk); #1;
      for (int n = 0; n < NE; n++) if (pend_set[n] && vld(n)) m_pend[n] = 1;
      if (et) begin
         m_pend[w] = 0;
         m_stk[m_sp] = w;
         m_sp++;
      end
      if (ret) begin
         if (m_sp > 0) m_sp--;
         m_fm = 0;
      end else if (fm_wr) m_fm = fm_din;
      pend_set = '0; ret = 1'b0; fm_wr = 1'b0;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      step("R9 reset state");

      // R1: reserved numbers never pend
      for (int i = 0; i < NE; i++) prio[i] = 8'h20;
      pend_set[0] = 1; pend_set[7] = 1; pend_set[8] = 1; pend_set[9] = 1;
      pend_set[10] = 1; pend_set[13] = 1;
      step("R1"); step("R1");

      // R10: fixed ranks, basepri does not touch them
      prio[16] = 8'h00; bp = 8'h20;
      pend_set[1] = 1; pend_set[2] = 1; pend_set[3] = 1; pend_set[16] = 1;
      step("R10");
      for (int k = 0; k < 4; k++) begin step("R10"); ret = 1'b1; step("R10"); end
      step("R10");

      // R3: truncated low bits give a tie, lowest number wins; truncated basepri is off
      do_reset();
      prio[16] = 8'h5F; prio[17] = 8'h40; bp = 8'h1F; prio[18] = 8'hE0;
      pend_set[16] = 1; pend_set[17] = 1;
      step("R3"); step("R3"); ret = 1'b1; step("R3"); step("R3");
      ret = 1'b1; step("R3"); pend_set[18] = 1; step("R3"); step("R3");

      // R4: same group with better subpriority cannot preempt
      do_reset();
      sub = 3'd6; prio[16] = 8'hA0; prio[17] = 8'h80; prio[18] = 8'h40;
      pend_set[16] = 1; step("R4"); step("R4");
      pend_set[17] = 1; step("R4"); step("R4"); step("R4");
      pend_set[18] = 1; step("R4"); step("R4");
      ret = 1'b1; step("R4"); ret = 1'b1; step("R4"); step("R4");

      // R5: nesting and restore on return
      do_reset();
      prio[16] = 8'h80; prio[17] = 8'h40; prio[18] = 8'h80;
      pend_set[16] = 1; step("R5"); step("R5");
      pend_set[17] = 1; step("R5"); step("R5");
      pend_set[18] = 1; step("R5"); step("R5");
      ret = 1'b1; step("R5"); step("R5");
      ret = 1'b1; step("R5"); step("R5"); step("R5");

      // R6: basepri floor
      do_reset();
      bp = 8'h40; prio[16] = 8'h40; prio[17] = 8'h20; prio[18] = 8'h60;
      pend_set[16] = 1; pend_set[17] = 1; pend_set[18] = 1;
      step("R6"); step("R6"); ret = 1'b1; step("R6"); step("R6");
      bp = 8'h00; step("R6"); ret = 1'b1; step("R6"); step("R6");

      // R7: primask leaves only reset, NMI and hard fault
      do_reset();
      pm = 1'b1; prio[16] = 8'h00;
      pend_set[3] = 1; pend_set[16] = 1; step("R7"); step("R7");
      ret = 1'b1; step("R7"); step("R7");
      pend_set[2] = 1; step("R7"); step("R7");
      ret = 1'b1; step("R7"); pm = 1'b0; step("R7"); step("R7");

      // R8: faultmask load, exemptions, clear on return
      do_reset();
      prio[16] = 8'h00; fm_wr = 1'b1; fm_din = 1'b1; step("R8");
      pend_set[3] = 1; pend_set[16] = 1; pend_set[2] = 1; step("R8"); step("R8");
      ret = 1'b1; step("R8"); step("R8");
      fm_wr = 1'b1; fm_din = 1'b1; ret = 1'b1; step("R8"); step("R8"); step("R8");

      // R2: tie among equal priorities
      do_reset();
      for (int i = 16; i < NE; i++) begin prio[i] = 8'h60; pend_set[i] = 1; end
      step("R2"); step("R2"); ret = 1'b1; step("R2"); step("R2");

      // R2: sweep every split setting with mixed stimulus
      do_reset();
      for (int s = 0; s < 8; s++) begin
         sub = 3'(s);
         for (int c = 0; c < 1500; c++) begin
            if (c % 200 == 0) for (int i = 0; i < NE; i++) prio[i] = 8'($urandom);
            if (c % 50 == 0) bp = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
            pm = ($urandom % 10 == 0);
            pend_set = NE'($urandom & $urandom & $urandom);
            ret = ($urandom % 5 == 0);
            if ($urandom % 20 == 0) begin fm_wr = 1'b1; fm_din = 1'($urandom); end
            step("R2");
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule